// File: doc/BRIEF.md
# Detect-and-Hold State Register

This block is a small sequential stage whose combinational next-state logic is guarded against transient faults without a correcting code. Each cycle the next-state function is evaluated, predicted check information is produced alongside it, and a checker compares the two. The checker is a cheap detecting code chosen when the block is elaborated: a single parity bit over the whole word, one parity bit per half word, or a second copy of the function with a bitwise compare.

When the checker reports a mismatch, the state register keeps the value it already holds. The hold lasts for every cycle in which the error stays present, however long that is. In the first clean cycle the register loads the freshly computed next state, and no restart or replay takes place. A fault-injection mask is XORed onto the primary copy of the combinational result, so a test can produce transient errors of any length and pattern. A saturating counter records how many cycles were held. Each storage bit stands for a master-slave pair, and the error inhibits only the slave half of the cycle.

Top module: `stall_guard_reg`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears state and stallCnt to zero.
- R2: In a cycle with no error, the next rising edge loads state with {state[W-2:0], state[W-1]} XOR inWord, the state rotated left by one bit and XORed with the input.
- R3: With the whole-word parity code (CODE = CK_PARITY), errFlag is 1 exactly when faultMask has an odd number of set bits.
- R4: With the split parity code (CODE = CK_SPLIT), errFlag is 1 when faultMask has an odd number of set bits in its low half (bits W/2-1..0), in its high half (bits W-1..W/2), or in both.
- R5: With the duplication code (CODE = CK_DUP), errFlag is 1 whenever faultMask is nonzero.
- R6: While errFlag is 1 at a rising edge, state keeps its previous value, for any number of consecutive cycles.
- R7: At the first rising edge where errFlag is 0 after a hold, state loads the next state computed from the held state and the current inputs, with no extra cycle.
- R8: stallCnt increases by one at each rising edge where errFlag is 1 and stays at 2^CNT_W-1 once it reaches that value. It is unchanged in other cycles.
- R9: A fault pattern that the selected code does not detect leaves errFlag at 0, and state loads the corrupted value (correct next state XOR faultMask).
- R10: errFlag and dataOut follow the current state and inputs within the same cycle. dataOut is the next state XOR faultMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inWord | input | W | Primary input word |
| faultMask | input | W | Test mask XORed onto the primary next-state copy |
| state | output | W | Registered state |
| dataOut | output | W | Combinational next-state word as checked (mask applied) |
| errFlag | output | 1 | Checker mismatch, combinational |
| stallCnt | output | CNT_W | Saturating count of held cycles |

## Verification
The case hardest to reach from the ports is a fault the code misses. Two flips in one half slip past both parity variants, while one flip in each half slips past only the whole-word parity. The bench drives both patterns to three instances, one per code, side by side. It then confirms that the corrupted word lands in state where the code is blind, and that the duplicate compare still holds. A mask held steady for more than 255 cycles drives the counter into saturation and proves that the hold has no length limit.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [1:0] {
    CK_PARITY = 2'd0,
    CK_SPLIT  = 2'd1,
    CK_DUP    = 2'd2
  } codeKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // slave half may take the master value
    logic countStall;  // this cycle is a held cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/stall_datapath.sv
module stall_datapath
  import stall_pkg::*;
#(
  parameter int W = 8,
  parameter codeKind_e CODE = CK_PARITY
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [W-1:0] inWord,
  input  logic [W-1:0] faultMask,
  input  ctrlStrobe_t strobe,
  output logic [W-1:0] stateQ,
  output logic [W-1:0] nextSeen,
  output logic        errRaw
);
  localparam int HALF = W / 2;

  function automatic logic [W-1:0] nextFn(input logic [W-1:0] s, input logic [W-1:0] i);
    return {s[W-2:0], s[W-1]} ^ i;
  endfunction

  logic [W-1:0] nextPrimary;
  assign nextPrimary = nextFn(stateQ, inWord);
  assign nextSeen    = nextPrimary ^ faultMask;

  generate
    if (CODE == CK_PARITY) begin : gParity
      // rotation keeps parity, so the prediction needs only state and input
      logic predBit;
      assign predBit = (^stateQ) ^ (^inWord);
      assign errRaw  = predBit ^ (^nextSeen);

      // R3
      parity_detect_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(faultMask) % 2 == 1) |-> errRaw);
    end else if (CODE == CK_SPLIT) begin : gSplit
      logic [W-1:0] rotState;
      logic predLo, predHi, missLo, missHi;
      assign rotState = {stateQ[W-2:0], stateQ[W-1]};
      assign predLo = (^rotState[HALF-1:0]) ^ (^inWord[HALF-1:0]);
      assign predHi = (^rotState[W-1:HALF]) ^ (^inWord[W-1:HALF]);
      assign missLo = predLo ^ (^nextSeen[HALF-1:0]);
      assign missHi = predHi ^ (^nextSeen[W-1:HALF]);
      assign errRaw = missLo | missHi;

      // R4
      split_detect_chk: assert property (@(posedge clk) disable iff (rst)
        (($countones(faultMask[HALF-1:0]) % 2 == 1) ||
         ($countones(faultMask[W-1:HALF]) % 2 == 1)) |-> errRaw);
    end else begin : gDup
      logic [W-1:0] nextShadow;
      assign nextShadow = nextFn(stateQ, inWord);
      assign errRaw     = |(nextShadow ^ nextSeen);

      // R5
      dup_detect_chk: assert property (@(posedge clk) disable iff (rst)
        (faultMask != '0) |-> errRaw);
    end
  endgenerate

  // each bit models a master-slave pair; load gates only the slave half
  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= '0;
    end else if (strobe.load) begin
      stateQ <= nextSeen;
    end
  end

  // R6
  hold_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    errRaw |=> $stable(stateQ));
endmodule

// File: rtl/stall_control.sv
module stall_control
  import stall_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             errIn,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] stallCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    strobe.load       = ~errIn;
    strobe.countStall = errIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stallCnt <= '0;
    end else if (strobe.countStall && (stallCnt != CNT_MAX)) begin
      stallCnt <= stallCnt + 1'b1;
    end
  end

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (errIn && stallCnt != CNT_MAX) |=> (stallCnt == $past(stallCnt) + 1'b1));
  // R8
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (stallCnt == CNT_MAX) |=> (stallCnt == CNT_MAX));
  // R8
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !errIn |=> $stable(stallCnt));
endmodule

// File: rtl/stall_guard_reg.sv
module stall_guard_reg
  import stall_pkg::*;
#(
  parameter int W = 8,
  parameter int CNT_W = 8,
  parameter codeKind_e CODE = CK_PARITY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     inWord,
  input  logic [W-1:0]     faultMask,
  output logic [W-1:0]     state,
  output logic [W-1:0]     dataOut,
  output logic             errFlag,
  output logic [CNT_W-1:0] stallCnt
);
  ctrlStrobe_t strobe;
  logic        errRaw;

  stall_datapath #(.W(W), .CODE(CODE)) uData (
    .clk(clk), .rst(rst), .inWord(inWord), .faultMask(faultMask),
    .strobe(strobe), .stateQ(state), .nextSeen(dataOut), .errRaw(errRaw)
  );

  stall_control #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .errIn(errRaw), .strobe(strobe), .stallCnt(stallCnt)
  );

  assign errFlag = errRaw;
endmodule

// File: tb/tb_stall_guard_reg.sv
`timescale 1ns/1ps
module tb_stall_guard_reg;
  import stall_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] inWord = '0;
  logic [7:0] faultMask = '0;
  always #2 clk = ~clk;

  logic [7:0] stateV [3];
  logic [7:0] dataV  [3];
  logic       errV   [3];
  logic [7:0] cntV   [3];

  stall_guard_reg #(.W(8), .CNT_W(8), .CODE(CK_PARITY)) dut (
    .clk(clk), .rst(rst), .inWord(inWord), .faultMask(faultMask),
    .state(stateV[0]), .dataOut(dataV[0]), .errFlag(errV[0]), .stallCnt(cntV[0]));
  stall_guard_reg #(.W(8), .CNT_W(8), .CODE(CK_SPLIT)) dutSplit (
    .clk(clk), .rst(rst), .inWord(inWord), .faultMask(faultMask),
    .state(stateV[1]), .dataOut(dataV[1]), .errFlag(errV[1]), .stallCnt(cntV[1]));
  stall_guard_reg #(.W(8), .CNT_W(8), .CODE(CK_DUP)) dutDup (
    .clk(clk), .rst(rst), .inWord(inWord), .faultMask(faultMask),
    .state(stateV[2]), .dataOut(dataV[2]), .errFlag(errV[2]), .stallCnt(cntV[2]));

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int mState [3];
  int mCnt   [3];

  task automatic chk(input string req, input int idx, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s code%0d %s actual=%0h expected=%0h", req, idx, what, act, exp);
    end
  endtask

  function automatic int countBits(input int v, input int lo, input int hi);
    int n = 0;
    for (int b = lo; b <= hi; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // detection rules taken from R3, R4, R5
  function automatic int detects(input int code, input int m);
    if (code == 0) return countBits(m, 0, 7) % 2;
    if (code == 1) return ((countBits(m, 0, 3) % 2) | (countBits(m, 4, 7) % 2));
    return (m != 0) ? 1 : 0;
  endfunction

  function automatic int nextOf(input int s, input int i);
    return (((s << 1) | (s >> 7)) & 8'hFF) ^ i;
  endfunction

  task automatic step(input int iw, input int m, input string req);
    int expErr [3];
    int expData [3];
    inWord = 8'(iw);
    faultMask = 8'(m);
    #1;
    for (int k = 0; k < 3; k++) begin
      expErr[k]  = detects(k, m);
      expData[k] = nextOf(mState[k], iw) ^ m;
      chk(req, k, "errFlag", int'(errV[k]), expErr[k]);   // R10
      chk(req, k, "dataOut", int'(dataV[k]), expData[k]); // R10
    end
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      if (expErr[k] != 0) begin
        if (mCnt[k] < 255) mCnt[k]++;
      end else begin
        mState[k] = expData[k];
      end
    end
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(req, k, "state", int'(stateV[k]), mState[k]);
      chk(req, k, "stallCnt", int'(cntV[k]), mCnt[k]);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      mState[k] = 0;
      mCnt[k] = 0;
      chk("R1", k, "state", int'(stateV[k]), 0);
      chk("R1", k, "stallCnt", int'(cntV[k]), 0);
    end
    rst = 1'b0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    doReset();
    // R2 plain operation under varied inputs
    for (int j = 0; j < 12; j++) step((j * 37 + 5) & 8'hFF, 0, "R2");
    step(8'hA5, 8'h00, "R2");
    // single flip seen by every code: R3 R4 R5, then R6 hold for three cycles
    step(8'h3C, 8'h01, "R3");
    step(8'h3C, 8'h01, "R6");
    step(8'h3C, 8'h01, "R6");
    // R7 resume in the first clean cycle
    step(8'h5A, 8'h00, "R7");
    // two flips in the low half: both parity codes blind, duplicate holds (R9, R5)
    step(8'h12, 8'h03, "R9");
    step(8'h34, 8'h00, "R7");
    // one flip per half: whole-word parity blind, split parity catches (R4, R9)
    step(8'h77, 8'h11, "R4");
    step(8'h21, 8'h00, "R7");
    // long hold: unlimited duration R6 and counter saturation R8
    for (int j = 0; j < 260; j++) step(8'h0F, 8'h80, "R8");
    step(8'hC3, 8'h00, "R7");
    step(8'h99, 8'h00, "R2");
    // mid-run reset clears state and counter
    doReset();
    step(8'h44, 8'h00, "R2");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule